// File: doc/BRIEF.md
# Aliased Register File with Configuration Lock

This block is the software-visible register bank of a timer-style peripheral. It decodes a simple word-addressed bus with separate write and read strobes and holds the enable bit, the configuration byte, the interrupt flags and enables, and a control and compare word for each channel. It also returns read-only words whose values come from the counter logic beside it. The counter and the channels sit outside this block. The block passes its register contents to them on plain output ports and takes their values back on plain input ports.

Every register appears in four windows that share one layout. Window 0 replaces the register with the written data. Window 1 sets the bits that are 1 in the data. Window 2 clears those bits. Window 3 inverts them. This lets software change single bits without a read-modify-write sequence. A key word guards the configuration. While the guard is closed, writes to the configuration, the interrupt enables and the channel words are dropped. The enable bit, the flags and the key word itself can still be written. Hardware flag events always win over a software clear that lands in the same cycle.

Top module: `alias_regfile`

## Requirements
- R1: After reset, every stored register is 0, the guard is open (`locked` = 0), `busRdData` is 0 and no command strobe is active.
- R2: A window-0 write stores the data ANDed with the register's writable mask: enable 0x1, configuration 0xFF, flags 0x1F, interrupt enable 0x1F, channel control 0x7F, channel compare 0xFFFFFFFF. Bits outside the mask read as 0.
- R3: A window-1 write ORs the data into the register, so only bits that are 1 in the data change.
- R4: A window-2 write clears the register bits that are 1 in the data.
- R5: A window-3 write inverts the register bits that are 1 in the data.
- R6: The key word (index 11) compares the low 16 bits of the written data, in any window. 0xAEE8 opens the guard and any other value closes it. Status word bit 1 reads 1 while the guard is closed, and status bit 0 mirrors `runStatus`.
- R7: While the guard is closed, writes in any window to the configuration, the interrupt enables and the channel control and compare words have no effect. The enable, flag and key words stay writable.
- R8: The version (index 0), status (4), pre-count (7), count (8), combined count (9), busy (10) and channel capture words ignore writes in every window. The combined count reads {mainCount[16:0], preCount}.
- R9: A write to the command word (index 3) computes the window operation on an all-zero value. Each resulting 1 bit pulses `cmdStrobe` for exactly the one cycle after the write edge. The word always reads 0.
- R10: A `hwFlagSet` bit forces its flag to 1 at the next edge, even when a software write to the flags clears that bit in the same cycle.
- R11: Word indices at or above 12 + 3*NUM_CH in any window are reserved. They read 0, and writes there change nothing.
- R12: The address is {window[1:0], word index[9:0]}. Channel c uses indices 12+3c (control), 13+3c (compare) and 14+3c (capture). `busRdData` holds the read value in the cycle after `busRdEn` and is 0 otherwise. A read returns the same value in every window.
- R13: `irq` is high exactly when some flag and its matching interrupt-enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | ADDR_W | {window, word index} |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, one cycle after the strobe |
| runStatus | input | 1 | Counter running, shown in status bit 0 |
| preCount | input | 15 | Pre-counter value |
| mainCount | input | 32 | Main counter value |
| syncBusy | input | 4 | Busy bits from the counter domain |
| capValue | input | 32*NUM_CH | Capture value per channel |
| hwFlagSet | input | 5 | Hardware flag set events |
| enableOut | output | 1 | Enable bit |
| cfgOut | output | 8 | Configuration byte |
| cmdStrobe | output | 2 | Single-cycle command pulses |
| flagsOut | output | 5 | Interrupt flags |
| irqEnOut | output | 5 | Interrupt enables |
| irq | output | 1 | Combined interrupt request |
| chCtrlOut | output | 7*NUM_CH | Channel control words |
| chCmpOut | output | 32*NUM_CH | Channel compare words |
| locked | output | 1 | Configuration guard closed |

## Verification
A wrong decode of the window or the word index appears on the register output ports one edge after the write. Either a different register changes, or the wrong bits move under set, clear or toggle. A guard state that does not match the last key shows up at once on `locked`, and one cycle after the next protected write on `cfgOut` or the channel outputs. A read-mux fault is visible on `busRdData` exactly one cycle after the read strobe. A flag-priority fault shows on `flagsOut` and `irq` at the edge where the hardware event and the software clear collide.

// File: rtl/arf_pkg.sv
package arf_pkg;

  // Top-level word indices; channels follow at TOP_WORDS.
  localparam int TOP_WORDS = 12;
  localparam int CH_WORDS  = 3;
  localparam int CH_IDX_W  = 4;
  localparam int KEY_W     = 16;

  localparam logic [3:0] ID_WORD   = 4'd0;
  localparam logic [3:0] EN_WORD   = 4'd1;
  localparam logic [3:0] CFG_WORD  = 4'd2;
  localparam logic [3:0] CMD_WORD  = 4'd3;
  localparam logic [3:0] STAT_WORD = 4'd4;
  localparam logic [3:0] FLAG_WORD = 4'd5;
  localparam logic [3:0] IEN_WORD  = 4'd6;
  localparam logic [3:0] PRE_WORD  = 4'd7;
  localparam logic [3:0] CNT_WORD  = 4'd8;
  localparam logic [3:0] COMB_WORD = 4'd9;
  localparam logic [3:0] BUSY_WORD = 4'd10;
  localparam logic [3:0] KEY_WORD  = 4'd11;

  localparam logic [31:0] EN_MASK   = 32'h0000_0001;
  localparam logic [31:0] CFG_MASK  = 32'h0000_00FF;
  localparam logic [31:0] CMD_MASK  = 32'h0000_0003;
  localparam logic [31:0] FLAG_MASK = 32'h0000_001F;
  localparam logic [31:0] IEN_MASK  = 32'h0000_001F;
  localparam logic [31:0] CTRL_MASK = 32'h0000_007F;
  localparam logic [31:0] CMP_MASK  = 32'hFFFF_FFFF;

  localparam logic [KEY_W-1:0] OPEN_KEY = 16'hAEE8;

  // Window index selects the write operation.
  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_TOGGLE = 2'd3
  } winOp_e;

  typedef struct packed {
    winOp_e                op;
    logic                  wrEnable;
    logic                  wrConfig;
    logic                  wrCommand;
    logic                  wrFlags;
    logic                  wrIrqEn;
    logic                  wrChCtrl;
    logic                  wrChCmp;
    logic                  rdGo;
    logic                  isChan;
    logic [3:0]            topIdx;
    logic [CH_IDX_W-1:0]   chIdx;
    logic [1:0]            chFld;
  } regStrobe_t;

  function automatic logic [31:0] applyOp(winOp_e op, logic [31:0] cur,
                                          logic [31:0] din, logic [31:0] mask);
    logic [31:0] res;
    case (op)
      OP_WRITE:  res = din;
      OP_SET:    res = cur | din;
      OP_CLEAR:  res = cur & ~din;
      default:   res = cur ^ din;
    endcase
    return res & mask;
  endfunction

endpackage

// File: rtl/arf_ctrl.sv
module arf_ctrl
  import arf_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [KEY_W-1:0] keyData,
  output regStrobe_t       strb,
  output logic             locked
);
  localparam int IDX_W     = ADDR_W - 2;
  localparam int NUM_WORDS = TOP_WORDS + CH_WORDS * NUM_CH;

  logic [IDX_W-1:0]    idx;
  logic [1:0]          win;
  logic                hit;
  logic                isChan;
  logic [CH_IDX_W-1:0] chIdx;
  logic [1:0]          chFld;
  logic                topWr;
  logic                chWr;
  logic                lockedQ;

  assign win    = busAddr[ADDR_W-1 -: 2];
  assign idx    = busAddr[IDX_W-1:0];
  assign hit    = idx < IDX_W'(NUM_WORDS);
  assign isChan = idx >= IDX_W'(TOP_WORDS);

  // Channel number and field found by matching the unrolled layout.
  always_comb begin
    chIdx = '0;
    chFld = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int f = 0; f < CH_WORDS; f++) begin
        if (idx == IDX_W'(TOP_WORDS + CH_WORDS * c + f)) begin
          chIdx = CH_IDX_W'(c);
          chFld = 2'(f);
        end
      end
    end
  end

  assign topWr = busWrEn && hit && !isChan;
  assign chWr  = busWrEn && hit && isChan && !lockedQ;

  always_comb begin
    strb           = '0;
    strb.op        = winOp_e'(win);
    strb.wrEnable  = topWr && (idx[3:0] == EN_WORD);
    strb.wrConfig  = topWr && (idx[3:0] == CFG_WORD) && !lockedQ;
    strb.wrCommand = topWr && (idx[3:0] == CMD_WORD);
    strb.wrFlags   = topWr && (idx[3:0] == FLAG_WORD);
    strb.wrIrqEn   = topWr && (idx[3:0] == IEN_WORD) && !lockedQ;
    strb.wrChCtrl  = chWr && (chFld == 2'd0);
    strb.wrChCmp   = chWr && (chFld == 2'd1);
    strb.rdGo      = busRdEn && hit;
    strb.isChan    = isChan;
    strb.topIdx    = idx[3:0];
    strb.chIdx     = chIdx;
    strb.chFld     = chFld;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockedQ <= 1'b0;
    end else if (topWr && (idx[3:0] == KEY_WORD)) begin
      lockedQ <= (keyData != OPEN_KEY);
    end
  end

  assign locked = lockedQ;

endmodule

// File: rtl/arf_datapath.sv
module arf_datapath
  import arf_pkg::*;
#(
  parameter int          NUM_CH  = 3,
  parameter logic [31:0] VERSION = 32'h0000_0001
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t             strb,
  input  logic [31:0]            wrData,
  input  logic                   lockedIn,
  input  logic                   runStatus,
  input  logic [14:0]            preCount,
  input  logic [31:0]            mainCount,
  input  logic [3:0]             syncBusy,
  input  logic [32*NUM_CH-1:0]   capValue,
  input  logic [4:0]             hwFlagSet,
  output logic [31:0]            rdData,
  output logic                   enableOut,
  output logic [7:0]             cfgOut,
  output logic [1:0]             cmdStrobe,
  output logic [4:0]             flagsOut,
  output logic [4:0]             irqEnOut,
  output logic                   irq,
  output logic [7*NUM_CH-1:0]    chCtrlOut,
  output logic [32*NUM_CH-1:0]   chCmpOut
);
  logic                     enableQ;
  logic [7:0]               cfgQ;
  logic [1:0]               cmdQ;
  logic [4:0]               flagsQ;
  logic [4:0]               ienQ;
  logic [NUM_CH-1:0][6:0]   chCtrlQ;
  logic [NUM_CH-1:0][31:0]  chCmpQ;
  logic [31:0]              rdVal;
  logic [31:0]              rdQ;
  logic [4:0]               flagsSw;

  assign flagsSw = strb.wrFlags ? 5'(applyOp(strb.op, 32'(flagsQ), wrData, FLAG_MASK)) : flagsQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      cfgQ    <= '0;
      cmdQ    <= '0;
      flagsQ  <= '0;
      ienQ    <= '0;
    end else begin
      if (strb.wrEnable) enableQ <= 1'(applyOp(strb.op, 32'(enableQ), wrData, EN_MASK));
      if (strb.wrConfig) cfgQ    <= 8'(applyOp(strb.op, 32'(cfgQ), wrData, CFG_MASK));
      if (strb.wrIrqEn)  ienQ    <= 5'(applyOp(strb.op, 32'(ienQ), wrData, IEN_MASK));
      // Command bits act on a zero value and self-clear next cycle.
      cmdQ   <= strb.wrCommand ? 2'(applyOp(strb.op, 32'd0, wrData, CMD_MASK)) : 2'b00;
      // Hardware set events win over any software clear.
      flagsQ <= flagsSw | hwFlagSet;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chCtrlQ[c] <= '0;
        chCmpQ[c]  <= '0;
      end else if (strb.chIdx == CH_IDX_W'(c)) begin
        if (strb.wrChCtrl) chCtrlQ[c] <= 7'(applyOp(strb.op, 32'(chCtrlQ[c]), wrData, CTRL_MASK));
        if (strb.wrChCmp)  chCmpQ[c]  <= applyOp(strb.op, chCmpQ[c], wrData, CMP_MASK);
      end
    end
  end

  always_comb begin
    rdVal = '0;
    if (strb.isChan) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (strb.chIdx == CH_IDX_W'(c)) begin
          case (strb.chFld)
            2'd0:    rdVal = 32'(chCtrlQ[c]);
            2'd1:    rdVal = chCmpQ[c];
            default: rdVal = capValue[32*c +: 32];
          endcase
        end
      end
    end else begin
      case (strb.topIdx)
        ID_WORD:   rdVal = VERSION;
        EN_WORD:   rdVal = 32'(enableQ);
        CFG_WORD:  rdVal = 32'(cfgQ);
        STAT_WORD: rdVal = {30'd0, lockedIn, runStatus};
        FLAG_WORD: rdVal = 32'(flagsQ);
        IEN_WORD:  rdVal = 32'(ienQ);
        PRE_WORD:  rdVal = 32'(preCount);
        CNT_WORD:  rdVal = mainCount;
        COMB_WORD: rdVal = {mainCount[16:0], preCount};
        BUSY_WORD: rdVal = 32'(syncBusy);
        default:   rdVal = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdQ <= '0;
    else       rdQ <= strb.rdGo ? rdVal : '0;
  end

  assign rdData    = rdQ;
  assign enableOut = enableQ;
  assign cfgOut    = cfgQ;
  assign cmdStrobe = cmdQ;
  assign flagsOut  = flagsQ;
  assign irqEnOut  = ienQ;
  assign irq       = |(flagsQ & ienQ);
  assign chCtrlOut = chCtrlQ;
  assign chCmpOut  = chCmpQ;

endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
  import arf_pkg::*;
#(
  parameter int          NUM_CH  = 3,
  parameter int          ADDR_W  = 12,
  parameter logic [31:0] VERSION = 32'h0000_0001
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [31:0]           busWrData,
  output logic [31:0]           busRdData,
  input  logic                  runStatus,
  input  logic [14:0]           preCount,
  input  logic [31:0]           mainCount,
  input  logic [3:0]            syncBusy,
  input  logic [32*NUM_CH-1:0]  capValue,
  input  logic [4:0]            hwFlagSet,
  output logic                  enableOut,
  output logic [7:0]            cfgOut,
  output logic [1:0]            cmdStrobe,
  output logic [4:0]            flagsOut,
  output logic [4:0]            irqEnOut,
  output logic                  irq,
  output logic [7*NUM_CH-1:0]   chCtrlOut,
  output logic [32*NUM_CH-1:0]  chCmpOut,
  output logic                  locked
);
  regStrobe_t strb;

  arf_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .keyData (busWrData[KEY_W-1:0]),
    .strb    (strb),
    .locked  (locked)
  );

  arf_datapath #(.NUM_CH(NUM_CH), .VERSION(VERSION)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (busWrData),
    .lockedIn  (locked),
    .runStatus (runStatus),
    .preCount  (preCount),
    .mainCount (mainCount),
    .syncBusy  (syncBusy),
    .capValue  (capValue),
    .hwFlagSet (hwFlagSet),
    .rdData    (busRdData),
    .enableOut (enableOut),
    .cfgOut    (cfgOut),
    .cmdStrobe (cmdStrobe),
    .flagsOut  (flagsOut),
    .irqEnOut  (irqEnOut),
    .irq       (irq),
    .chCtrlOut (chCtrlOut),
    .chCmpOut  (chCmpOut)
  );

endmodule

// File: rtl/alias_regfile_chk.sv
module alias_regfile_chk
  import arf_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWrEn,
  input logic                  busRdEn,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [31:0]           busWrData,
  input logic [31:0]           busRdData,
  input logic [4:0]            hwFlagSet,
  input logic                  enableOut,
  input logic [7:0]            cfgOut,
  input logic [1:0]            cmdStrobe,
  input logic [4:0]            flagsOut,
  input logic [4:0]            irqEnOut,
  input logic [7*NUM_CH-1:0]   chCtrlOut,
  input logic [32*NUM_CH-1:0]  chCmpOut,
  input logic                  locked
);
  localparam int IDX_W = ADDR_W - 2;

  // R2: without a write, no stored register moves.
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ($stable(cfgOut) && $stable(enableOut) && $stable(irqEnOut)
                  && $stable(chCtrlOut) && $stable(chCmpOut)));

  // R6: the open key clears the guard at the next edge.
  p_key_opens_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[IDX_W-1:0] == IDX_W'(KEY_WORD) && busWrData[KEY_W-1:0] == OPEN_KEY)
    |=> !locked);

  // R7: protected registers are frozen while the guard is closed.
  p_locked_freeze_r7: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> ($stable(cfgOut) && $stable(irqEnOut) && $stable(chCtrlOut) && $stable(chCmpOut)));

  // R9: a command pulse only follows a bus write.
  p_cmd_after_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe != 2'b00) |-> $past(busWrEn));

  // R10: a hardware event always leaves its flag set.
  p_hw_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hwFlagSet != 5'd0) |=> ((flagsOut & $past(hwFlagSet)) == $past(hwFlagSet)));

  // R12: read data is zero when no read was strobed.
  p_idle_read_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> (busRdData == 32'd0));

endmodule

bind alias_regfile alias_regfile_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_alias_regfile.sv
module test_alias_regfile;
  localparam int          NUM_CH = 3;
  localparam int          ADDR_W = 12;
  localparam logic [31:0] VER    = 32'h0002_0107;
  localparam int          NVEC   = 19;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 busWrEn = 1'b0;
  logic                 busRdEn = 1'b0;
  logic [ADDR_W-1:0]    busAddr = '0;
  logic [31:0]          busWrData = '0;
  logic [31:0]          busRdData;
  logic                 runStatus = 1'b1;
  logic [14:0]          preCount = 15'h1234;
  logic [31:0]          mainCount = 32'h000A_5A5A;
  logic [3:0]           syncBusy = 4'hA;
  logic [32*NUM_CH-1:0] capValue = {32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
  logic [4:0]           hwFlagSet = '0;
  logic                 enableOut;
  logic [7:0]           cfgOut;
  logic [1:0]           cmdStrobe;
  logic [4:0]           flagsOut;
  logic [4:0]           irqEnOut;
  logic                 irq;
  logic [7*NUM_CH-1:0]  chCtrlOut;
  logic [32*NUM_CH-1:0] chCmpOut;
  logic                 locked;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #10 clk = ~clk;

  alias_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .VERSION(VER)) i_alias_regfile (.*);

  // {window, write word, write data, read word, expected, tag number}
  localparam logic [89:0] VEC [NVEC] = '{
    {2'd0, 10'd2,  32'h1234_56A5, 10'd2,  32'h0000_00A5, 4'd2},  // R2 cfg masked
    {2'd0, 10'd6,  32'hFFFF_FFF3, 10'd6,  32'h0000_0013, 4'd2},  // R2 ien masked
    {2'd1, 10'd2,  32'h0000_010A, 10'd2,  32'h0000_00AF, 4'd3},  // R3 set
    {2'd2, 10'd2,  32'h0000_000F, 10'd2,  32'h0000_00A0, 4'd4},  // R4 clear
    {2'd3, 10'd2,  32'h0000_00FF, 10'd2,  32'h0000_005F, 4'd5},  // R5 toggle
    {2'd0, 10'd16, 32'hDEAD_BEEF, 10'd16, 32'hDEAD_BEEF, 4'd2},  // R2 ch1 compare
    {2'd3, 10'd16, 32'hFFFF_0000, 10'd16, 32'h2152_BEEF, 4'd5},  // R5 ch1 compare
    {2'd0, 10'd18, 32'h0000_00FF, 10'd18, 32'h0000_007F, 4'd2},  // R2 ch2 control
    {2'd2, 10'd18, 32'h0000_0070, 10'd18, 32'h0000_000F, 4'd4},  // R4 ch2 control
    {2'd1, 10'd1,  32'h0000_0003, 10'd1,  32'h0000_0001, 4'd3},  // R3 enable
    {2'd0, 10'd0,  32'hFFFF_FFFF, 10'd0,  VER,           4'd8},  // R8 version
    {2'd3, 10'd4,  32'hFFFF_FFFF, 10'd4,  32'h0000_0001, 4'd8},  // R8 status
    {2'd1, 10'd14, 32'hFFFF_FFFF, 10'd14, 32'h1111_1111, 4'd8},  // R8 capture
    {2'd2, 10'd9,  32'hFFFF_FFFF, 10'd9,  32'h2D2D_1234, 4'd8},  // R8 combined
    {2'd0, 10'd7,  32'hFFFF_FFFF, 10'd7,  32'h0000_1234, 4'd8},  // R8 pre-count
    {2'd3, 10'd10, 32'h0000_000F, 10'd10, 32'h0000_000A, 4'd8},  // R8 busy
    {2'd0, 10'd21, 32'hFFFF_FFFF, 10'd21, 32'h0000_0000, 4'd11}, // R11 reserved
    {2'd0, 10'd3,  32'h0000_0003, 10'd3,  32'h0000_0000, 4'd9},  // R9 reads zero
    {2'd1, 10'd20, 32'h0000_0000, 10'd20, 32'h3333_3333, 4'd8}   // R8 capture ch2
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] win, logic [9:0] word, logic [31:0] data);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = {win, word}; busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(logic [1:0] win, logic [9:0] word, output logic [31:0] val);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = {win, word};
    @(negedge clk);
    busRdEn = 1'b0;
    val = busRdData;
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 cfgOut",    32'(cfgOut), 32'h0);
    check("R1 enableOut", 32'(enableOut), 32'h0);
    check("R1 flagsOut",  32'(flagsOut), 32'h0);
    check("R1 chCmpOut",  chCmpOut[31:0], 32'h0);
    check("R1 locked",    32'(locked), 32'h0);
    check("R1 busRdData", busRdData, 32'h0);
    check("R1 cmdStrobe", 32'(cmdStrobe), 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [89:0] v;
      v = VEC[i];
      busWrite(v[89:88], v[87:78], v[77:46]);
      busRead(2'd0, v[45:36], rv);
      check($sformatf("R%0d vector %0d", v[3:0], i), rv, v[35:4]);
    end

    // R12: alias read and idle data
    busRead(2'd3, 10'd2, rv);
    check("R12 alias read", rv, 32'h0000_005F);
    @(negedge clk);
    check("R12 idle zero", busRdData, 32'h0);

    // R9: command pulses
    @(negedge clk);
    busWrEn = 1'b1; busAddr = {2'd0, 10'd3}; busWrData = 32'h2;
    @(posedge clk); #1;
    check("R9 strobe", 32'(cmdStrobe), 32'h2);
    @(negedge clk); busWrEn = 1'b0;
    @(posedge clk); #1;
    check("R9 self clear", 32'(cmdStrobe), 32'h0);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = {2'd3, 10'd3}; busWrData = 32'h1;
    @(posedge clk); #1;
    check("R9 toggle window", 32'(cmdStrobe), 32'h1);
    @(negedge clk);
    busAddr = {2'd2, 10'd3}; busWrData = 32'h3;
    @(posedge clk); #1;
    check("R9 clear window", 32'(cmdStrobe), 32'h0);
    @(negedge clk); busWrEn = 1'b0;

    // R6 and R7: close the guard
    busWrite(2'd0, 10'd11, 32'h0000_1234);
    check("R6 closed", 32'(locked), 32'h1);
    busRead(2'd0, 10'd4, rv);
    check("R6 status", rv, 32'h3);
    busWrite(2'd0, 10'd2, 32'h11);
    check("R7 cfg frozen", 32'(cfgOut), 32'h5F);
    busWrite(2'd1, 10'd6, 32'h0C);
    check("R7 ien frozen", 32'(irqEnOut), 32'h13);
    busWrite(2'd0, 10'd16, 32'h0);
    check("R7 cmp frozen", chCmpOut[63:32], 32'h2152_BEEF);
    busWrite(2'd2, 10'd18, 32'hF);
    check("R7 ctrl frozen", 32'(chCtrlOut[20:14]), 32'h0F);
    busWrite(2'd0, 10'd5, 32'h15);
    check("R7 flags writable", 32'(flagsOut), 32'h15);
    busWrite(2'd2, 10'd1, 32'h1);
    check("R7 enable writable", 32'(enableOut), 32'h0);
    busWrite(2'd1, 10'd11, 32'hFFFF_AEE8);
    check("R6 opened", 32'(locked), 32'h0);
    busWrite(2'd0, 10'd2, 32'h11);
    check("R6 cfg after open", 32'(cfgOut), 32'h11);

    // R10: hardware set against software clear
    @(negedge clk);
    busWrEn = 1'b1; busAddr = {2'd2, 10'd5}; busWrData = 32'h1F; hwFlagSet = 5'h01;
    @(negedge clk);
    busWrEn = 1'b0; hwFlagSet = 5'h08;
    check("R10 collision", 32'(flagsOut), 32'h01);
    @(negedge clk);
    hwFlagSet = 5'h00;
    check("R10 hw only", 32'(flagsOut), 32'h09);

    // R13: interrupt request
    check("R13 irq high", 32'(irq), 32'h1);
    busWrite(2'd2, 10'd5, 32'h1);
    check("R13 irq low", 32'(irq), 32'h0);

    // R11: reserved gap and alias
    busWrite(2'd0, 10'd600, 32'hFF);
    check("R11 cfg untouched", 32'(cfgOut), 32'h11);
    busRead(2'd0, 10'd600, rv);
    check("R11 gap reads zero", rv, 32'h0);
    busRead(2'd1, 10'd25, rv);
    check("R11 alias reserved", rv, 32'h0);

    done = 1'b1;
    finishRun();
  end

endmodule